// File: doc/BRIEF.md
# Frequency-Change Recovery Watchdog

This block guards a clock frequency change requested by software. Two byte-wide registers are written over a simple write port. The control register holds a 4-bit timeout code, a fallback-policy bit and a reset-enable bit. The frequency register holds the frequency code the clock generator should use. A frequency write always takes effect at once. When the timeout code is nonzero at that moment, the write also arms a watchdog. Boot software that survives the new frequency writes a zero timeout code, which disarms the watchdog and keeps the new setting.

If the watchdog expires, the block raises an alarm flag, pulses an active-low system reset when that is enabled, and starts timing again. The first expiry only resets. Every later expiry also moves the frequency code back to a fallback value: either the code captured from the strap pins during reset, or the software code that was in force before the last change. This repeats until software clears the timeout code. The timeout for code n is n × BASE_TICKS × TICK_DIV clock cycles.

The control is a three-state machine:

- `ST_IDLE` means no watchdog is running.
- `ST_WATCH` means the watchdog is armed and has not yet expired.
- `ST_RETRY` means at least one expiry has happened.

The transitions are as follows:

- *arm*: `ST_IDLE`/`ST_WATCH`/`ST_RETRY` → `ST_WATCH`, on a frequency write while the timeout code is nonzero.
- *disarm*: any state → `ST_IDLE`, on a control write whose code is zero, or on a frequency write while the code is zero.
- *first expiry*: `ST_WATCH` → `ST_RETRY`.
- *retry expiry*: `ST_RETRY` → `ST_RETRY`, with a frequency revert.

Top module: `freq_recovery_wdog`

## Requirements
- R1: A frequency write (`wr_sel`=1) made while the stored timeout code is 0 updates `freq_code` on the next cycle. It leaves `wd_active` at 0, and no alarm or reset pulse ever follows from it.
- R2: A frequency write made while the timeout code is nonzero sets `freq_code` to `wr_data` and `prev_code` to the former `freq_code`, and sets `wd_active` to 1, all on the next cycle.
- R3: A control write (`wr_sel`=0) with `wr_data[3:0]`=0 sets `wd_active` and `alarm` to 0 on the next cycle and keeps `freq_code`. This holds even when it lands in the same cycle as an expiry, in which case no reset pulse starts.
- R4: On the first expiry after arming, `alarm` becomes 1 and `freq_code` is unchanged. The timer restarts with the current code.
- R5: On the second and every later expiry, the block does everything the first expiry does and also replaces `freq_code` with the fallback code. It keeps doing this once per timeout period while the code stays nonzero.
- R6: The fallback is the strap code captured in reset when control bit 6 is 0. It is `prev_code` when bit 6 is 1.
- R7: Control bit 7 enables the reset pulse. With bit 7 at 0, expiries still set `alarm` but `sys_rst_n` stays 1.
- R8: An enabled expiry drives `sys_rst_n` low for exactly RST_PULSE_CYC cycles, starting the cycle after the expiry.
- R9: While `rst_n` is 0, `strap_code` is captured and both `freq_code` and `prev_code` take its value. `alarm`=0, `sys_rst_n`=1 and `wd_active`=0 after reset.
- R10: A frequency write while the watchdog runs restarts the timer in the first-expiry stage, so the next expiry does not revert. If the write coincides with an expiry, the write wins and no pulse starts.
- R11: Control bits 4 and 5 are ignored: writing them cannot set `alarm`. A nonzero timeout code written while running does not restart the timer; it sets the length of the next reload, including a reload in the same cycle.
- R12: With code n, an expiry acts exactly n × BASE_TICKS × TICK_DIV cycles after the arming write or after the previous expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap capture while low |
| strap_code | input | FREQ_W | Hardware strap frequency code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control register, 1 = frequency register |
| wr_data | input | 8 | Write data |
| freq_code | output | FREQ_W | Frequency code in force |
| prev_code | output | FREQ_W | Software code before the latest change |
| alarm | output | 1 | Watchdog alarm flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| wd_active | output | 1 | Watchdog armed |

## Verification
A watchdog expiry and a software write can fall in the same cycle. The write may be a zero timeout code, a new frequency code, or a nonzero code that changes policy and reset enable. The bench follows a cycle model of the timer and waits until one cycle of the period remains. It then issues the write so that it is sampled at the expiry edge, both in directed cases and at random. It judges the result against the rule that a clearing or frequency write overrides the expiry, while a nonzero control write lets the expiry act with the old policy and reset-enable bits.

// File: rtl/frw_pkg.sv
package frw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WATCH = 2'd1,
        ST_RETRY = 2'd2
    } wd_state_e;

    localparam int  CODE_W  = 4;
    localparam int  POL_BIT = 6;
    localparam int  REN_BIT = 7;
    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_FREQ = 1'b1;
endpackage

// File: rtl/frw_timer.sv
module frw_timer #(
    parameter int TICK_DIV   = 200000,
    parameter int BASE_TICKS = 1,
    parameter int CODE_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              expire
);
    localparam int PRE_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int MAX_TICKS = ((1 << CODE_W) - 1) * BASE_TICKS;
    localparam int TCK_W     = $clog2(MAX_TICKS + 1);

    logic [PRE_W-1:0] pre_q;
    logic [TCK_W-1:0] tck_q;
    logic             wrap;

    assign wrap   = (pre_q == PRE_W'(TICK_DIV - 1));
    assign expire = run && wrap && (tck_q == TCK_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            tck_q <= '0;
        end else if (load) begin
            pre_q <= '0;
            tck_q <= TCK_W'(int'(code) * BASE_TICKS);
        end else if (run) begin
            if (wrap) begin
                pre_q <= '0;
                if (tck_q != '0) tck_q <= tck_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/frw_pulse.sv
module frw_pulse #(
    parameter int WIDTH = 600000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse_n
);
    localparam int CNT_W = $clog2(WIDTH + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= CNT_W'(WIDTH);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign pulse_n = (cnt_q == '0);
endmodule

// File: rtl/freq_recovery_wdog.sv
module freq_recovery_wdog
    import frw_pkg::*;
#(
    parameter int FREQ_W        = 8,
    parameter int TICK_DIV      = 200000,
    parameter int BASE_TICKS    = 1,
    parameter int RST_PULSE_CYC = 600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREQ_W-1:0] strap_code,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [7:0]        wr_data,
    output logic [FREQ_W-1:0] freq_code,
    output logic [FREQ_W-1:0] prev_code,
    output logic              alarm,
    output logic              sys_rst_n,
    output logic              wd_active
);
    wd_state_e         state_q, state_d;
    logic [CODE_W-1:0] tmo_q, tmo_nxt;
    logic              pol_q, ren_q;
    logic [FREQ_W-1:0] freq_q, prev_q, strap_q;
    logic              alarm_q;
    logic              ctrl_wr, freq_wr, clear_wr;
    logic              expire, load, fire, revert;
    logic              stage_retry;

    assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
    assign freq_wr  = wr_en && (wr_sel == SEL_FREQ);
    assign clear_wr = ctrl_wr && (wr_data[CODE_W-1:0] == '0);
    assign tmo_nxt  = ctrl_wr ? wr_data[CODE_W-1:0] : tmo_q;

    // configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q <= '0;
            pol_q <= 1'b0;
            ren_q <= 1'b0;
        end else if (ctrl_wr) begin
            tmo_q <= wr_data[CODE_W-1:0];
            pol_q <= wr_data[POL_BIT];
            ren_q <= wr_data[REN_BIT];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: software writes take priority over a same-cycle expiry
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        fire    = 1'b0;
        if (clear_wr) begin
            state_d = ST_IDLE;
        end else if (freq_wr) begin
            if (tmo_q != '0) begin
                state_d = ST_WATCH;
                load    = 1'b1;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_WATCH: if (expire) begin
                              state_d = ST_RETRY;
                              load    = 1'b1;
                              fire    = 1'b1;
                          end
                ST_RETRY: if (expire) begin
                              load    = 1'b1;
                              fire    = 1'b1;
                          end
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    assign revert = fire && (state_q == ST_RETRY);

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_code;
            freq_q  <= strap_code;
            prev_q  <= strap_code;
            alarm_q <= 1'b0;
        end else begin
            if (clear_wr)  alarm_q <= 1'b0;
            else if (fire) alarm_q <= 1'b1;
            if (freq_wr) begin
                prev_q <= freq_q;
                freq_q <= wr_data[FREQ_W-1:0];
            end else if (revert) begin
                freq_q <= pol_q ? prev_q : strap_q;
            end
        end
    end

    frw_timer #(
        .TICK_DIV   (TICK_DIV),
        .BASE_TICKS (BASE_TICKS),
        .CODE_W     (CODE_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .run    (wd_active),
        .code   (tmo_nxt),
        .expire (expire)
    );

    frw_pulse #(
        .WIDTH (RST_PULSE_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fire && ren_q),
        .pulse_n (sys_rst_n)
    );

    assign stage_retry = (state_q == ST_RETRY);
    assign wd_active   = (state_q != ST_IDLE);
    assign freq_code   = freq_q;
    assign prev_code   = prev_q;
    assign alarm       = alarm_q;
endmodule

// File: rtl/frw_chk.sv
module frw_chk #(
    parameter int FREQ_W        = 8,
    parameter int RST_PULSE_CYC = 600000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [7:0]        wr_data,
    input logic [3:0]        tmo_q,
    input logic              ren_q,
    input logic              stage_retry,
    input logic [FREQ_W-1:0] freq_code,
    input logic              alarm,
    input logic              sys_rst_n,
    input logic              wd_active
);
    int unsigned low_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || sys_rst_n) low_cnt <= 0;
        else                     low_cnt <= low_cnt + 1;
    end

    AST_ZERO_CODE_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && tmo_q == 4'd0) |=> !wd_active); // R1

    AST_CHANGE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && tmo_q != 4'd0) |=> (wd_active && freq_code == $past(wr_data[FREQ_W-1:0]))); // R2

    AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[3:0] == 4'd0) |=> (!wd_active && !alarm)); // R3

    AST_ALARM_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(wd_active)); // R4

    AST_REVERT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(freq_code) |-> ($past(wr_en && wr_sel) || $past(stage_retry))); // R5

    AST_PULSE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> ($past(ren_q) && $past(wd_active))); // R7

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt <= RST_PULSE_CYC); // R8
endmodule

bind freq_recovery_wdog frw_chk #(
    .FREQ_W        (FREQ_W),
    .RST_PULSE_CYC (RST_PULSE_CYC)
) u_frw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .tmo_q       (tmo_q),
    .ren_q       (ren_q),
    .stage_retry (stage_retry),
    .freq_code   (freq_code),
    .alarm       (alarm),
    .sys_rst_n   (sys_rst_n),
    .wd_active   (wd_active)
);

// File: tb/freq_recovery_wdog_bench.sv
`timescale 1ns/1ps
module freq_recovery_wdog_bench;
    localparam int TD   = 4;
    localparam int BT   = 2;
    localparam int RP   = 3;
    localparam int UNIT = TD * BT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] strap = 8'h5A;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] freq_code, prev_code;
    logic       alarm, sys_rst_n, wd_active;

    always #2.5 clk = ~clk;

    freq_recovery_wdog #(
        .FREQ_W (8), .TICK_DIV (TD), .BASE_TICKS (BT), .RST_PULSE_CYC (RP)
    ) u_freq_recovery_wdog (
        .clk (clk), .rst_n (rst_n), .strap_code (strap),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .freq_code (freq_code), .prev_code (prev_code), .alarm (alarm),
        .sys_rst_n (sys_rst_n), .wd_active (wd_active)
    );

    int    nvec = 0;
    int    nfail = 0;
    bit    chk_on = 1'b0;
    string cur_req = "R9";

    // cycle model built from the requirements
    int         m_st = 0, m_left = 0, m_pulse = 0;
    logic [7:0] m_freq, m_prev, m_strap;
    logic       m_alarm = 1'b0;
    logic [3:0] m_tmo = 4'd0;
    logic       m_pol = 1'b0, m_ren = 1'b0;

    always @(posedge clk) begin : model
        logic c_w, f_w, clr, ex;
        logic [3:0] tn;
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_pulse = 0; m_alarm = 1'b0;
            m_tmo = 4'd0; m_pol = 1'b0; m_ren = 1'b0;
            m_strap = strap; m_freq = strap; m_prev = strap;
        end else begin
            c_w = wr_en && !wr_sel;
            f_w = wr_en && wr_sel;
            clr = c_w && (wr_data[3:0] == 4'd0);
            ex  = (m_st != 0) && (m_left == 1);
            tn  = c_w ? wr_data[3:0] : m_tmo;
            if (m_pulse > 0) m_pulse = m_pulse - 1;
            if (clr) begin
                m_st = 0; m_alarm = 1'b0;
            end else if (f_w) begin
                m_prev = m_freq; m_freq = wr_data;
                if (m_tmo != 4'd0) begin m_st = 1; m_left = int'(m_tmo) * UNIT; end
                else m_st = 0;
            end else if (ex) begin
                if (m_ren) m_pulse = RP;
                m_alarm = 1'b1;
                if (m_st == 2) m_freq = m_pol ? m_prev : m_strap;
                m_st = 2; m_left = int'(tn) * UNIT;
            end else if (m_st != 0) begin
                m_left = m_left - 1;
            end
            if (c_w) begin m_tmo = wr_data[3:0]; m_pol = wr_data[6]; m_ren = wr_data[7]; end
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            nvec++;
            if (freq_code !== m_freq || prev_code !== m_prev || alarm !== m_alarm ||
                sys_rst_n !== (m_pulse == 0) || wd_active !== (m_st != 0)) begin
                nfail++;
                $display("FAIL %s: freq/prev/alarm/rst_n/active got %h/%h/%b/%b/%b exp %h/%h/%b/%b/%b",
                         cur_req, freq_code, prev_code, alarm, sys_rst_n, wd_active,
                         m_freq, m_prev, m_alarm, (m_pulse == 0), (m_st != 0));
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: %s got %h exp %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_expiry_edge();
        for (int k = 0; k < 400; k++) begin
            if (m_st != 0 && m_left == 1) break;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run hung, got timeout exp completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        chk_on = 1'b1;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        cur_req = "R9";
        chk("R9", "freq", freq_code, 8'h5A);
        chk("R9", "prev", prev_code, 8'h5A);
        chk("R9", "alarm/rst_n/active", {5'd0, alarm, sys_rst_n, wd_active}, 8'h02);

        cur_req = "R11";
        wr(1'b0, 8'h30);
        chk("R11", "alarm after bits 4-5 write", {7'd0, alarm}, 8'h00);

        cur_req = "R1";
        wr(1'b1, 8'h11);
        idle(30);
        chk("R1", "freq", freq_code, 8'h11);
        chk("R1", "active/rst_n", {6'd0, wd_active, sys_rst_n}, 8'h01);

        cur_req = "R2";
        wr(1'b0, 8'h81);
        wr(1'b1, 8'h22);
        chk("R2", "freq/prev", {freq_code[3:0], prev_code[3:0]}, 8'h21);
        chk("R2", "active", {7'd0, wd_active}, 8'h01);
        cur_req = "R12";
        idle(UNIT - 2);
        chk("R12", "alarm before period", {7'd0, alarm}, 8'h00);
        idle(2);
        cur_req = "R4";
        chk("R4", "alarm/rst_n", {6'd0, alarm, sys_rst_n}, 8'h02);
        chk("R4", "freq kept", freq_code, 8'h22);
        cur_req = "R8";
        idle(2);
        chk("R8", "rst_n still low", {7'd0, sys_rst_n}, 8'h00);
        idle(1);
        chk("R8", "rst_n released", {7'd0, sys_rst_n}, 8'h01);
        cur_req = "R5";
        idle(5);
        chk("R6", "revert to strap", freq_code, 8'h5A);

        cur_req = "R3";
        wait_expiry_edge();
        wr(1'b0, 8'h00);
        chk("R3", "alarm/rst_n/active", {5'd0, alarm, sys_rst_n, wd_active}, 8'h02);
        idle(3 * UNIT);
        chk("R3", "freq kept", freq_code, 8'h5A);

        cur_req = "R6";
        wr(1'b0, 8'h40);
        wr(1'b1, 8'h77);
        wr(1'b0, 8'hC1);
        wr(1'b1, 8'h33);
        idle(2 * UNIT);
        chk("R6", "revert to previous", freq_code, 8'h77);

        cur_req = "R10";
        wait_expiry_edge();
        wr(1'b1, 8'h99);
        chk("R10", "freq on coincident write", freq_code, 8'h99);
        idle(UNIT - 1);
        chk("R10", "first stage after restart", freq_code, 8'h99);

        cur_req = "R11";
        wait_expiry_edge();
        wr(1'b0, 8'h42);
        chk("R11", "old enable pulses", {7'd0, sys_rst_n}, 8'h00);

        cur_req = "R7";
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h44);
        idle(UNIT);
        chk("R7", "alarm/rst_n", {6'd0, alarm, sys_rst_n}, 8'h03);
        wr(1'b0, 8'h00);

        cur_req = "R12";
        for (int i = 0; i < 5000; i++) begin
            int r;
            r = int'($urandom % 24);
            if (i == 2500) begin
                cur_req = "R9";
                rst_n = 1'b0; strap = 8'hA3;
                idle(2);
                rst_n = 1'b1;
                idle(1);
                chk("R9", "strap recaptured", freq_code, 8'hA3);
                cur_req = "R12";
            end else if (r == 0) begin
                wr(1'b0, {$urandom % 16, 2'd0, 2'($urandom % 4)});
            end else if (r == 1) begin
                wr(1'b1, 8'($urandom));
            end else if (r == 2 && m_st != 0) begin
                wait_expiry_edge();
                wr(1'($urandom % 2), {$urandom % 16, 2'd0, 2'($urandom % 4)});
            end else begin
                idle(1);
            end
        end
        summary();
        $finish;
    end
endmodule